// File: doc/BRIEF.md
# Video Crosspoint Routing Control

This block holds the routing setup for an eight-output video crosspoint matrix and drives the switch decoders of that matrix. Each output has a 3-bit choice of input, a flag that ties its buffer input to ground, and a buffer-enable flag. Setup data arrives in one of two formats, chosen by a pin. The parallel format carries a 3-bit output address and a 4-bit command. The serial format is a 32-bit shift chain. The chain's last bit comes out on a pin so that several devices can be chained.

Loading uses two ranks of state. Accepted write strobes fill a staging rank, and the routing outputs show only the second rank. A latch input moves the staging rank into the second rank. Depending on a mode pin, this happens on the latch's rising edge or continuously while the latch is low. Some parallel commands also force the transfer. All inputs are synchronous to `clk`. A strobe or latch edge is seen as a low-to-high change between two samples of the clock.

Top module: `xp_route_ctl`

## Requirements
- R1: After reset, every output selects input 0, its buffer is disabled and its input is not grounded. `ser_o` is 0.
- R2: A write is taken only on a rising edge of `wr_i` while `ce_n_i` is low and `ce_i` is high. A strobe outside that window changes neither rank nor the serial chain.
- R3: In parallel mode (`ser_mode_i`=0), a command with bit 3 = 0 sets the staging selection of output `addr_i` to `data_i[2:0]` and clears its ground flag. Its enable is left as it was, and the routing outputs do not change.
- R4: Parallel commands 4'b1000 and 4'b1001 set the ground flag of the addressed output in the staging rank. A later selection command clears it.
- R5: Command 4'b1010 clears the addressed staging enable and causes no transfer. Command 4'b1011 sets it and copies the whole updated staging rank to the outputs on the same clock edge.
- R6: Command 4'b1100 clears every enable and 4'b1101 sets every enable. Both transfer the updated staging rank at once. Command 4'b1110 only transfers.
- R7: Command 4'b1111 transfers the staging rank only if `latch_i` is high on the clock edge where the write is taken.
- R8: With `edge_mode_i`=1, the outputs take the staging rank on a rising edge of `latch_i`. A falling or steady latch has no effect.
- R9: With `edge_mode_i`=0, the outputs follow the staging rank one clock later while `latch_i` is low, and hold while it is high.
- R10: In serial mode, each accepted strobe shifts `data_i[0]` into bit 0 of a 32-bit chain. `data_i[3:1]` and `addr_i` are ignored. Output k reads chain bits [4k+3:4k], so output 7 is sent first, MSB first. A field with bit 3 = 0 routes bits 2..0 with the buffer enabled. 4'b1000 and 4'b1001 ground the input with the buffer enabled and select 0. Any other field disables the buffer and selects 0 with no ground.
- R11: `ser_o` is chain bit 31, which is the `data_i[0]` value accepted 32 strobes earlier, or 0 if fewer than 32 strobes have been taken since reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| wr_i | input | 1 | Write strobe, acts on its rising edge |
| ce_n_i | input | 1 | Chip enable, active low |
| ce_i | input | 1 | Chip enable, active high |
| ser_mode_i | input | 1 | 1 = serial chain, 0 = parallel command |
| edge_mode_i | input | 1 | 1 = latch acts on its rising edge, 0 = transparent while low |
| latch_i | input | 1 | Transfer control for the second rank |
| addr_i | input | 3 | Output address for parallel commands |
| data_i | input | 4 | Parallel command; bit 0 is the serial data input |
| ser_o | output | 1 | Last bit of the serial chain, for chaining devices |
| sel_o | output | 24 | Input selection per output, 3 bits each, output k at [3k+2:3k] |
| buf_en_o | output | 8 | Buffer enable per output |
| gnd_o | output | 8 | Buffer input grounded per output |

## Verification
A strobe or latch edge that inputs set up before clock edge n shows its effect on the outputs and on `ser_o` right after edge n. This applies to staging writes, command transfers, latch-edge transfers and shifts. In transparent-latch mode a staging write reaches the outputs one edge later, at n+1. The driver counts clock edges and tags every expected snapshot with the edge index at which it falls due. The monitor compares each snapshot on the falling clock after that edge, so the outputs are always read half a period away from any edge that could change them.

// File: rtl/xp_pkg.sv
package xp_pkg;
    localparam int SEL_W  = 3;
    localparam int CODE_W = SEL_W + 1;

    typedef struct packed {
        logic             en;
        logic             gnd;
        logic [SEL_W-1:0] sel;
    } route_t;

    typedef enum logic [SEL_W-1:0] {
        CC_GND_A      = 3'd0,
        CC_GND_B      = 3'd1,
        CC_ONE_OFF    = 3'd2,
        CC_ONE_ON     = 3'd3,
        CC_ALL_OFF    = 3'd4,
        CC_ALL_ON     = 3'd5,
        CC_SYNC       = 3'd6,
        CC_SOFT_LATCH = 3'd7
    } ctl_code_e;

    typedef struct packed {
        logic route;
        logic ground;
        logic one_off;
        logic one_on;
        logic all_off;
        logic all_on;
        logic xfer;
        logic xfer_if_latch;
    } cmd_t;

    localparam route_t ROUTE_RESET = '{en: 1'b0, gnd: 1'b0, sel: '0};
endpackage

// File: rtl/xp_edge_det.sv
module xp_edge_det #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] sig_i,
    output logic [W-1:0] rise_o
);
    logic [W-1:0] sig_d, sig_q;

    always_comb begin
        sig_d  = sig_i;
        rise_o = sig_i & ~sig_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sig_q <= '0;
        else        sig_q <= sig_d;
    end

    // a held-high input never produces two pulses in a row
    AST_RISE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (rise_o != '0) |=> ((rise_o & $past(rise_o)) == '0)); // R2
endmodule

// File: rtl/xp_cmd_decode.sv
module xp_cmd_decode
    import xp_pkg::*;
(
    input  logic [CODE_W-1:0] code_i,
    output cmd_t              cmd_o
);
    always_comb begin
        cmd_o = '0;
        if (!code_i[CODE_W-1]) begin
            cmd_o.route = 1'b1;
        end else begin
            unique case (ctl_code_e'(code_i[SEL_W-1:0]))
                CC_GND_A,
                CC_GND_B:      cmd_o.ground = 1'b1;
                CC_ONE_OFF:    cmd_o.one_off = 1'b1;
                CC_ONE_ON: begin
                    cmd_o.one_on = 1'b1;
                    cmd_o.xfer   = 1'b1;
                end
                CC_ALL_OFF: begin
                    cmd_o.all_off = 1'b1;
                    cmd_o.xfer    = 1'b1;
                end
                CC_ALL_ON: begin
                    cmd_o.all_on = 1'b1;
                    cmd_o.xfer   = 1'b1;
                end
                CC_SYNC:       cmd_o.xfer = 1'b1;
                CC_SOFT_LATCH: cmd_o.xfer_if_latch = 1'b1;
                default:       cmd_o = '0;
            endcase
        end
    end
endmodule

// File: rtl/xp_field_decode.sv
module xp_field_decode
    import xp_pkg::*;
(
    input  logic [CODE_W-1:0] code_i,
    output route_t            route_o
);
    always_comb begin
        route_o = ROUTE_RESET;
        if (!code_i[CODE_W-1]) begin
            route_o.sel = code_i[SEL_W-1:0];
            route_o.en  = 1'b1;
        end else if (code_i[SEL_W-1:1] == '0) begin
            route_o.gnd = 1'b1;
            route_o.en  = 1'b1;
        end
    end
endmodule

// File: rtl/xp_shift_chain.sv
module xp_shift_chain #(
    parameter int LEN = 32
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           shift_i,
    input  logic           bit_i,
    output logic [LEN-1:0] chain_o,
    output logic           msb_o
);
    logic [LEN-1:0] chain_d, chain_q;

    always_comb begin
        chain_d = chain_q;
        if (shift_i) chain_d = {chain_q[LEN-2:0], bit_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign chain_o = chain_q;
    assign msb_o   = chain_q[LEN-1];

    AST_SHIFT_LSB: assert property (@(posedge clk) disable iff (!rst_n)
        shift_i |=> (chain_o[0] == $past(bit_i))); // R10
    AST_SHIFT_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
        shift_i |=> (msb_o == $past(chain_o[LEN-2]))); // R11
endmodule

// File: rtl/xp_route_ctl.sv
module xp_route_ctl
    import xp_pkg::*;
#(
    parameter int N_OUT = 8,
    localparam int ADDR_W  = (N_OUT > 1) ? $clog2(N_OUT) : 1,
    localparam int CHAIN_W = N_OUT * CODE_W
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_i,
    input  logic                   ce_n_i,
    input  logic                   ce_i,
    input  logic                   ser_mode_i,
    input  logic                   edge_mode_i,
    input  logic                   latch_i,
    input  logic [ADDR_W-1:0]      addr_i,
    input  logic [CODE_W-1:0]      data_i,
    output logic                   ser_o,
    output logic [N_OUT*SEL_W-1:0] sel_o,
    output logic [N_OUT-1:0]       buf_en_o,
    output logic [N_OUT-1:0]       gnd_o
);
    // N_OUT is expected to be a power of two so every address is a valid output

    typedef struct packed {
        route_t [N_OUT-1:0] r1;
        route_t [N_OUT-1:0] r2;
    } ctl_state_t;

    ctl_state_t         st_d, st_q;
    logic [1:0]         rise;
    logic               wr_rise, latch_rise;
    logic               strobe, par_wr, ser_shift, xfer_cmd;
    cmd_t               cmd;
    logic [CHAIN_W-1:0] chain;
    logic               chain_msb;
    route_t [N_OUT-1:0] field_r;
    route_t [N_OUT-1:0] eff;

    xp_edge_det #(.W(2)) u_edges (
        .clk    (clk),
        .rst_n  (rst_n),
        .sig_i  ({latch_i, wr_i}),
        .rise_o (rise)
    );

    assign wr_rise    = rise[0];
    assign latch_rise = rise[1];
    assign strobe     = wr_rise & ~ce_n_i & ce_i;
    assign par_wr     = strobe & ~ser_mode_i;
    assign ser_shift  = strobe & ser_mode_i;

    xp_cmd_decode u_cmd (
        .code_i (data_i),
        .cmd_o  (cmd)
    );

    xp_shift_chain #(.LEN(CHAIN_W)) u_chain (
        .clk     (clk),
        .rst_n   (rst_n),
        .shift_i (ser_shift),
        .bit_i   (data_i[0]),
        .chain_o (chain),
        .msb_o   (chain_msb)
    );

    for (genvar g = 0; g < N_OUT; g++) begin : g_field
        xp_field_decode u_fd (
            .code_i  (chain[g*CODE_W +: CODE_W]),
            .route_o (field_r[g])
        );
    end

    // what a latch transfer copies: the chain fields in serial mode, else the staging rank
    assign eff = ser_mode_i ? field_r : st_q.r1;

    always_comb begin
        st_d     = st_q;
        xfer_cmd = 1'b0;
        if (par_wr) begin
            if (cmd.all_off || cmd.all_on) begin
                for (int i = 0; i < N_OUT; i++) st_d.r1[i].en = cmd.all_on;
            end
            if (cmd.route) begin
                st_d.r1[addr_i].sel = data_i[SEL_W-1:0];
                st_d.r1[addr_i].gnd = 1'b0;
            end
            if (cmd.ground)  st_d.r1[addr_i].gnd = 1'b1;
            if (cmd.one_off) st_d.r1[addr_i].en  = 1'b0;
            if (cmd.one_on)  st_d.r1[addr_i].en  = 1'b1;
            xfer_cmd = cmd.xfer | (cmd.xfer_if_latch & latch_i);
        end
        if (xfer_cmd) begin
            st_d.r2 = st_d.r1;
        end else if (edge_mode_i ? latch_rise : ~latch_i) begin
            st_d.r2 = eff;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.r1 <= {N_OUT{ROUTE_RESET}};
            st_q.r2 <= {N_OUT{ROUTE_RESET}};
        end else begin
            st_q <= st_d;
        end
    end

    for (genvar g = 0; g < N_OUT; g++) begin : g_out
        assign sel_o[g*SEL_W +: SEL_W] = st_q.r2[g].sel;
        assign buf_en_o[g]             = st_q.r2[g].en;
        assign gnd_o[g]                = st_q.r2[g].gnd;
    end
    assign ser_o = chain_msb;

    AST_GATED_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_rise && (ce_n_i || !ce_i)) |=> ($stable(st_q.r1) && $stable(chain))); // R2
    AST_EDGE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_mode_i && !latch_rise && !xfer_cmd) |=> $stable(st_q.r2)); // R8
    AST_LEVEL_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (!edge_mode_i && !latch_i && !xfer_cmd) |=> (st_q.r2 == $past(eff))); // R9
    AST_ALL_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (par_wr && cmd.all_off) |=> (buf_en_o == '0)); // R6
    AST_SOFT_LATCH_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (par_wr && cmd.xfer_if_latch && !latch_i && edge_mode_i) |=> $stable(st_q.r2)); // R7
    AST_ONE_ON_XFER: assert property (@(posedge clk) disable iff (!rst_n)
        (par_wr && cmd.one_on) |=> (st_q.r2 == st_q.r1)); // R5
endmodule

// File: tb/sim_xp_route_ctl.sv
`timescale 1ns/100ps
module sim_xp_route_ctl;
    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic        rst_n, wr, ce_n, ce, ser_mode, edge_mode, latch;
    logic [2:0]  addr;
    logic [3:0]  data;
    logic        ser_o;
    logic [23:0] sel_o;
    logic [7:0]  buf_en_o, gnd_o;

    xp_route_ctl u0 (
        .clk(clk), .rst_n(rst_n), .wr_i(wr), .ce_n_i(ce_n), .ce_i(ce),
        .ser_mode_i(ser_mode), .edge_mode_i(edge_mode), .latch_i(latch),
        .addr_i(addr), .data_i(data), .ser_o(ser_o), .sel_o(sel_o),
        .buf_en_o(buf_en_o), .gnd_o(gnd_o)
    );

    int tests = 0, fails = 0, cyc = 0;
    bit done = 0;
    always @(posedge clk) cyc <= cyc + 1;

    // bench model: staging rank m1*, output rank m2*, serial chain
    logic [7:0][2:0] m1s, m2s;
    logic [7:0]      m1e, m1g, m2e, m2g;
    logic [31:0]     m_chain;
    bit              m_edge, m_latch, m_ser;

    typedef struct {
        int          due;
        logic [23:0] sel;
        logic [7:0]  en;
        logic [7:0]  gnd;
        bit          chk_ser;
        logic        ser;
        string       tag;
    } exp_t;
    exp_t sbq[$];

    function automatic logic [4:0] fdec(logic [3:0] c);
        if (!c[3])             return {2'b10, c[2:0]};
        else if (c[2:1] == 0)  return 5'b11000;
        else                   return 5'b00000;
    endfunction

    task automatic push(int dly, string tag, bit cs = 0, logic s = 0);
        exp_t e;
        e.due = cyc + dly; e.sel = m2s; e.en = m2e; e.gnd = m2g;
        e.chk_ser = cs; e.ser = s; e.tag = tag;
        sbq.push_back(e);
    endtask

    task automatic copy_eff();
        if (m_ser) begin
            for (int k = 0; k < 8; k++) {m2e[k], m2g[k], m2s[k]} = fdec(m_chain[4*k +: 4]);
        end else begin
            m2s = m1s; m2e = m1e; m2g = m1g;
        end
    endtask

    // monitor: compare every snapshot whose clock edge has just passed
    always @(negedge clk) begin
        for (int i = sbq.size() - 1; i >= 0; i--) begin
            if (sbq[i].due == cyc) begin
                tests++;
                if (sel_o !== sbq[i].sel || buf_en_o !== sbq[i].en || gnd_o !== sbq[i].gnd ||
                    (sbq[i].chk_ser && ser_o !== sbq[i].ser)) begin
                    fails++;
                    $display("FAIL %s @%0d: sel=%h/%h en=%h/%h gnd=%h/%h ser=%b/%b (actual/expected)",
                             sbq[i].tag, cyc, sel_o, sbq[i].sel, buf_en_o, sbq[i].en,
                             gnd_o, sbq[i].gnd, ser_o, sbq[i].ser);
                end
                sbq.delete(i);
            end
        end
    end

    task automatic par_cmd(logic [2:0] a, logic [3:0] c, string tag);
        bit x = 0;
        @(negedge clk);
        addr = a; data = c; wr = 1'b1;
        if (!ce_n && ce) begin
            if (!c[3]) begin m1s[a] = c[2:0]; m1g[a] = 1'b0; end
            else case (c[2:0])
                3'd0, 3'd1: m1g[a] = 1'b1;
                3'd2: m1e[a] = 1'b0;
                3'd3: begin m1e[a] = 1'b1; x = 1; end
                3'd4: begin m1e = '0; x = 1; end
                3'd5: begin m1e = '1; x = 1; end
                3'd6: x = 1;
                default: x = m_latch;
            endcase
            if (x) begin m2s = m1s; m2e = m1e; m2g = m1g; end
        end
        push(1, tag);
        if (!m_edge && !m_latch) begin copy_eff(); push(2, tag); end
        @(negedge clk);
        wr = 1'b0;
    endtask

    task automatic ser_bit(logic b, logic [2:0] noise, string tag);
        @(negedge clk);
        addr = noise; data = {noise, b}; wr = 1'b1;
        if (!ce_n && ce) m_chain = {m_chain[30:0], b};
        push(1, tag, 1, m_chain[31]);
        @(negedge clk);
        wr = 1'b0;
    endtask

    task automatic ser_word(logic [31:0] w, string tag);
        for (int i = 31; i >= 0; i--) ser_bit(w[i], 3'(i * 5 + 3), tag);
    endtask

    task automatic latch_set(logic v, string tag);
        @(negedge clk);
        latch = v;
        if ((m_edge && v && !m_latch) || (!m_edge && !v)) copy_eff();
        m_latch = v;
        push(1, tag);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: run not finished (actual hung, expected done)");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        rst_n = 0; wr = 0; ce_n = 0; ce = 1; ser_mode = 0; edge_mode = 1; latch = 0;
        addr = 0; data = 0;
        m1s = '0; m2s = '0; m1e = '0; m1g = '0; m2e = '0; m2g = '0; m_chain = '0;
        m_edge = 1; m_latch = 0; m_ser = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        push(1, "R1 reset", 1, 1'b0);

        // R3/R4: staging writes stay hidden, R8 rising latch shows them
        par_cmd(3, 4'b0101, "R3 route staged");
        par_cmd(4, 4'b1000, "R4 ground staged");
        latch_set(1, "R8 latch rise");
        par_cmd(1, 4'b0111, "R8 latch held high");
        latch_set(0, "R8 latch fall");
        // R5/R6
        par_cmd(3, 4'b1011, "R5 enable one with transfer");
        par_cmd(0, 4'b1101, "R6 all on");
        par_cmd(2, 4'b1010, "R5 disable one no transfer");
        par_cmd(0, 4'b1110, "R6 sync");
        par_cmd(4, 4'b0010, "R4 route clears ground");
        // R7 soft latch
        par_cmd(0, 4'b1111, "R7 soft latch with latch low");
        latch_set(1, "R8 latch rise");
        par_cmd(5, 4'b0110, "R7 staged");
        par_cmd(0, 4'b1111, "R7 soft latch with latch high");
        // R2 gating
        ce_n = 1;
        par_cmd(6, 4'b0011, "R2 ce_n high ignored");
        par_cmd(0, 4'b1100, "R2 ce_n high all off ignored");
        ce_n = 0; ce = 0;
        par_cmd(6, 4'b0100, "R2 ce low ignored");
        ce = 1;
        par_cmd(7, 4'b0001, "R2 enabled write");
        par_cmd(0, 4'b1110, "R2 only enabled write shows");
        par_cmd(0, 4'b1100, "R6 all off");

        // R9 level mode; latch currently high
        @(negedge clk); edge_mode = 0; m_edge = 0;
        par_cmd(2, 4'b0011, "R9 latch high holds");
        latch_set(0, "R9 latch low passes");
        par_cmd(6, 4'b0110, "R9 follow one cycle later");
        par_cmd(6, 4'b1011, "R9 enable follows");
        latch_set(1, "R9 latch high");
        par_cmd(6, 4'b0001, "R9 held");
        @(negedge clk); edge_mode = 1; m_edge = 1;

        // R10/R11 serial chain
        @(negedge clk); ser_mode = 1; m_ser = 1;
        latch_set(0, "R8 fall no effect");
        ser_word({4'b0110, 4'b1000, 4'b0001, 4'b1010, 4'b0111, 4'b1111, 4'b0000, 4'b1001},
                 "R11 ser out zeros");
        latch_set(1, "R10 serial fields decoded");
        latch_set(0, "R10 fall");
        ce = 0;
        ser_bit(1'b1, 3'd7, "R2 gated shift ignored");
        ce = 1;
        ser_word({4'b0011, 4'b1001, 4'b1101, 4'b0101, 4'b1000, 4'b0010, 4'b0100, 4'b0111},
                 "R11 ser out carries first word");
        latch_set(1, "R10 second word decoded");

        repeat (4) @(negedge clk);
        if (sbq.size() != 0) begin
            fails++;
            $display("FAIL scoreboard: %0d pending (actual), 0 (expected)", sbq.size());
        end
        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule